// File: doc/BRIEF.md
# Supply Reset Sequencer

This block generates a system reset from three supply-good flags and a manual reset request. The flags come from external threshold comparators. The manual request is an active-low level from a pushbutton or a debug host. All four inputs are asynchronous levels. Each input passes through a two-stage synchroniser and then a glitch filter. A fault is recognised only after the input has been bad for a programmable number of consecutive clock samples. The minimum width for the supply flags and the minimum width for the manual request are set separately.

Reset asserts one cycle after any recognised fault. It stays asserted while any fault remains. It is released only after every input has been good for a complete release delay. The delay is given in milliseconds and converted to clock cycles from the clock frequency. A fault during the delay clears the delay, and the delay starts again from zero. The block drives two reset outputs, one active-low and one active-high, each from its own flop. It also reports which input produced the most recent recognised fault.

Top module: `supply_reset_seq`

## Requirements
- R1: `sys_rst_n_o` can be high only when `man_rst_n_i` is 1 and all three bits of `rail_good_i` are 1. Every other one of the 16 input combinations drives `sys_rst_n_o` low once it has been held long enough to be recognised.
- R2: `sys_rst_o` is always the complement of `sys_rst_n_o`.
- R3: Suppose all inputs become good just before clock edge k, and the filtered fault has been recognised. Then `sys_rst_n_o` rises at edge k+2+DLY_CYC, and not earlier. DLY_CYC = (CLK_HZ/1000)*DELAY_MS.
- R4: A fault recognised during the release delay asserts reset again. The full delay is then counted again from the moment the inputs become good.
- R5: A manual request recognised as low asserts reset. After `man_rst_n_i` returns high, the same full release delay of R3 runs before release.
- R6: A supply flag that is low for N consecutive sampled clocks causes a reset if and only if N >= RAIL_W. RAIL_W = ceil(CLK_HZ*RAIL_MIN_NS/1e9), with a minimum of 1. A recognised drop starting just before edge k asserts reset at edge k+2+RAIL_W.
- R7: A manual request that is low for fewer than MAN_W consecutive sampled clocks has no effect on the outputs. MAN_W is computed from MAN_MIN_NS in the same way as RAIL_W.
- R8: While `arst_n` is low, `sys_rst_n_o` is 0. After `arst_n` rises with all inputs good, reset stays asserted until the first full delay completes.
- R9: `cause_o` gives the input whose fault was most recently recognised. The encoding is 0 for rail bit 0, 1 for rail bit 1, 2 for rail bit 2 and 3 for manual. It reads 3 after `arst_n`. When faults are recognised in the same cycle, the lowest code wins.
- R10: The delay counter saturates at its terminal count. With all inputs held good, the outputs stay released for as long as the inputs remain good and do not wrap back into reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous initial reset, active low |
| rail_good_i | input | 3 | Supply-good flags from the comparators; 1 means the supply is good |
| man_rst_n_i | input | 1 | Manual reset request, active low |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |
| cause_o | output | 2 | Code of the most recent recognised fault |

## Verification
The bench builds the block with CLK_HZ = 1 MHz, DELAY_MS = 1, RAIL_MIN_NS = 6000 and MAN_MIN_NS = 3000. This gives a release delay of 1000 cycles and filter widths of 6 and 3 samples. With these values the bench can sweep all 16 input combinations, and each sweep step includes a full release. It can also check the exact fall and rise edges, and pulses one sample shorter than each filter width. A hold of 1500 cycles runs past the 1024 states of the 10-bit delay counter, so the saturation check of R10 is meaningful.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    localparam int unsigned NUM_RAILS = 3;
    localparam int unsigned NUM_SRC   = NUM_RAILS + 1;

    typedef enum logic [1:0] {
        CAUSE_RAIL0  = 2'd0,
        CAUSE_RAIL1  = 2'd1,
        CAUSE_RAIL2  = 2'd2,
        CAUSE_MANUAL = 2'd3
    } cause_e;

    // Converts a duration in ns to clock cycles, rounding up, never below 1.
    function automatic int unsigned ns_to_cyc(input longint unsigned hz,
                                              input longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 64'd1) c = 64'd1;
        return int'(c);
    endfunction

    function automatic int unsigned ms_to_cyc(input longint unsigned hz,
                                              input longint unsigned ms);
        longint unsigned c;
        c = (hz / 64'd1000) * ms;
        if (c < 64'd1) c = 64'd1;
        return int'(c);
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_i,
    output logic q_o
);
    logic [1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[0], d_i};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= {2{RST_VAL}};
        else         stage_q <= stage_d;
    end

    assign q_o = stage_q[1];
endmodule

// File: rtl/rsup_filter.sv
module rsup_filter #(
    parameter int unsigned MIN_W = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic good_i,
    output logic fault_o
);
    localparam int unsigned CW = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] TERM = CW'(MIN_W);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (good_i)             cnt_d = '0;
        else if (cnt_q != TERM) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= TERM;
        else         cnt_q <= cnt_d;
    end

    assign fault_o = (cnt_q == TERM);

    assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!arst_n)
        cnt_q <= TERM);
    assert_fault_needs_bad_R6: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(fault_o) |-> $past(!good_i));
    assert_good_clears_R3: assert property (@(posedge clk) disable iff (!arst_n)
        good_i |=> !fault_o);
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import rsup_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned DELAY_MS    = 200,
    parameter int unsigned RAIL_MIN_NS = 6000,
    parameter int unsigned MAN_MIN_NS  = 100
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic [2:0] rail_good_i,
    input  logic       man_rst_n_i,
    output logic       sys_rst_n_o,
    output logic       sys_rst_o,
    output logic [1:0] cause_o
);
    localparam int unsigned DLY_CYC = ms_to_cyc(CLK_HZ, DELAY_MS);
    localparam int unsigned RAIL_W  = ns_to_cyc(CLK_HZ, RAIL_MIN_NS);
    localparam int unsigned MAN_W   = ns_to_cyc(CLK_HZ, MAN_MIN_NS);
    localparam int unsigned DLY_W   = $clog2(DLY_CYC + 1);
    localparam logic [DLY_W-1:0] DLY_TERM = DLY_W'(DLY_CYC);

    typedef struct packed {
        logic [DLY_W-1:0]   dly;
        logic               rst_n;
        logic               rst;
        cause_e             cause;
        logic [NUM_SRC-1:0] flt_prev;
    } seq_t;

    logic [NUM_SRC-1:0] raw, fault, rise;
    logic               all_ok, rel;
    seq_t               s_d, s_q;

    assign raw = {man_rst_n_i, rail_good_i};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int unsigned W = (g < NUM_RAILS) ? RAIL_W : MAN_W;
        logic synced;
        rsup_sync #(.RST_VAL(1'b0)) u_sync (
            .clk(clk), .arst_n(arst_n), .d_i(raw[g]), .q_o(synced)
        );
        rsup_filter #(.MIN_W(W)) u_filt (
            .clk(clk), .arst_n(arst_n), .good_i(synced), .fault_o(fault[g])
        );
    end

    always_comb begin
        s_d          = s_q;
        all_ok       = ~|fault;
        rise         = fault & ~s_q.flt_prev;
        s_d.flt_prev = fault;

        if (!all_ok)                s_d.dly = '0;
        else if (s_q.dly != DLY_TERM) s_d.dly = s_q.dly + 1'b1;

        rel       = all_ok && (s_d.dly == DLY_TERM);
        s_d.rst_n = rel;
        s_d.rst   = !rel;

        if      (rise[0]) s_d.cause = CAUSE_RAIL0;
        else if (rise[1]) s_d.cause = CAUSE_RAIL1;
        else if (rise[2]) s_d.cause = CAUSE_RAIL2;
        else if (rise[3]) s_d.cause = CAUSE_MANUAL;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s_q.dly      <= '0;
            s_q.rst_n    <= 1'b0;
            s_q.rst      <= 1'b1;
            s_q.cause    <= CAUSE_MANUAL;
            s_q.flt_prev <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sys_rst_n_o = s_q.rst_n;
    assign sys_rst_o   = s_q.rst;
    assign cause_o     = s_q.cause;

    assert_outputs_complement_R2: assert property (@(posedge clk) disable iff (!arst_n)
        sys_rst_o == !sys_rst_n_o);
    assert_fault_asserts_R1: assert property (@(posedge clk) disable iff (!arst_n)
        (|fault) |=> !sys_rst_n_o);
    assert_release_full_delay_R3: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(sys_rst_n_o) |-> (s_q.dly == DLY_TERM));
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!arst_n)
        s_q.dly <= DLY_TERM);
    assert_fall_has_cause_R9: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(sys_rst_n_o) |-> $past(|fault));
endmodule

// File: tb/tb_supply_reset_seq.sv
module tb_supply_reset_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ  = 1_000_000;
    localparam int DLY_MS  = 1;
    localparam int RAIL_NS = 6000;
    localparam int MAN_NS  = 3000;
    localparam int DLY     = (CLK_HZ / 1000) * DLY_MS;
    localparam int RAIL_W  = ((CLK_HZ / 1000) * RAIL_NS + 999_999) / 1_000_000;
    localparam int MAN_W   = ((CLK_HZ / 1000) * MAN_NS + 999_999) / 1_000_000;
    localparam int RISE_LAT = 3 + DLY;

    logic       clk = 1'b0;
    logic       arst_n;
    logic [2:0] rail;
    logic       man_n;
    logic       rst_n, rst;
    logic [1:0] cause;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    supply_reset_seq #(
        .CLK_HZ(CLK_HZ), .DELAY_MS(DLY_MS),
        .RAIL_MIN_NS(RAIL_NS), .MAN_MIN_NS(MAN_NS)
    ) dut (
        .clk(clk), .arst_n(arst_n), .rail_good_i(rail), .man_rst_n_i(man_n),
        .sys_rst_n_o(rst_n), .sys_rst_o(rst), .cause_o(cause)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rst(input string req, input bit exp_n);
        chk(rst_n == exp_n, req, int'(rst_n), int'(exp_n));
        chk(rst == !exp_n, {req, " R2"}, int'(rst), int'(!exp_n));
    endtask

    // Holds all inputs good for n cycles and counts cycles where reset shows.
    task automatic hold_high(input int n, input string req);
        int miss = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (rst_n !== 1'b1) miss++;
        end
        chk(miss == 0, req, miss, 0);
    endtask

    task automatic settle_release();
        rail  = 3'b111;
        man_n = 1'b1;
        tick(RISE_LAT + 2);
    endtask

    initial begin
        arst_n = 1'b0;
        rail   = 3'b111;
        man_n  = 1'b1;
        tick(5);
        chk_rst("R8 reset state", 1'b0);
        chk(cause == 2'd3, "R9 reset cause", cause, 3);
        arst_n = 1'b1;
        tick(RISE_LAT - 1);
        chk_rst("R8 held before first delay", 1'b0);
        tick(1);
        chk_rst("R8 first release", 1'b1);

        // R1: all 16 combinations of {man, rail[2:0]}
        for (int v = 0; v < 16; v++) begin
            rail  = v[2:0];
            man_n = v[3];
            tick(3 + RAIL_W + 2);
            chk_rst("R1 truth table", v == 15);
            settle_release();
            chk_rst("R1 recovery", 1'b1);
        end

        // R6 exact fall edge, R3 exact rise edge, R9 cause
        rail = 3'b011;
        tick(3 + RAIL_W - 1);
        chk_rst("R6 before fall edge", 1'b1);
        tick(1);
        chk_rst("R6 fall edge", 1'b0);
        chk(cause == 2'd2, "R9 cause rail2", cause, 2);
        rail = 3'b111;
        tick(RISE_LAT - 1);
        chk_rst("R3 before rise edge", 1'b0);
        tick(1);
        chk_rst("R3 rise edge", 1'b1);

        // R6 glitch one sample short is ignored
        rail = 3'b110;
        tick(RAIL_W - 1);
        rail = 3'b111;
        hold_high(20, "R6 short rail glitch");
        // R6 glitch of exactly RAIL_W is recognised
        rail = 3'b110;
        tick(RAIL_W);
        rail = 3'b111;
        tick(3);
        chk_rst("R6 full-width rail drop", 1'b0);
        chk(cause == 2'd0, "R9 cause rail0", cause, 0);
        settle_release();

        // R7 manual glitch one sample short is ignored
        man_n = 1'b0;
        tick(MAN_W - 1);
        man_n = 1'b1;
        hold_high(20, "R7 short manual glitch");
        // R5 manual pulse of MAN_W and full delay afterwards
        man_n = 1'b0;
        tick(MAN_W);
        man_n = 1'b1;
        tick(3);
        chk_rst("R5 manual asserts", 1'b0);
        chk(cause == 2'd3, "R9 cause manual", cause, 3);
        tick(RISE_LAT - 3 - 1);
        chk_rst("R5 before manual release", 1'b0);
        tick(1);
        chk_rst("R5 manual release", 1'b1);

        // R4 fault in the middle of the delay restarts it
        rail = 3'b101;
        tick(RAIL_W + 2);
        rail = 3'b111;
        tick(DLY / 2);
        chk_rst("R4 mid-delay still held", 1'b0);
        rail = 3'b101;
        tick(RAIL_W);
        rail = 3'b111;
        chk(cause == 2'd1, "R9 cause rail1", cause, 1);
        tick(RISE_LAT - 1);
        chk_rst("R4 restarted delay not done", 1'b0);
        tick(1);
        chk_rst("R4 release after restart", 1'b1);

        // R9 priority on simultaneous faults
        rail = 3'b100;
        tick(RAIL_W + 3);
        chk(cause == 2'd0, "R9 simultaneous priority", cause, 0);
        settle_release();

        // R10 no wrap of the delay counter
        hold_high(1500, "R10 saturation");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule